// File: doc/BRIEF.md
# Lock-Aware LRU Victim Selector

This block chooses which way of one set in a 4-way set-associative cache receives the next fill. The set's recent-use history comes in as a 6-bit pairwise-age code, and the block applies two lock controls to it. Each lock covers either way 2 or way 3. A locked way drops out of the normal victim search, and the oldest remaining way is chosen. In DSP mode, a prefetch fill can be steered straight into a locked way when that way's load bit is also set.

The miss logic pulses a request strobe. One cycle later the chosen way appears on a registered output, together with a one-cycle valid pulse. A separate combinational helper takes the current age code and a touched way, and returns the updated code in which that way is the most recently used. The cache writes this code back on a hit or a fill.

Top module: `lock_lru_victim`

## Requirements
- R1: While reset is asserted (rstN low), victimValid is 0 and victimWay is 0.
- R2: victimValid is 1 in exactly the cycles that follow a cycle with missReq high, so back-to-back requests give back-to-back pulses. The way chosen from the inputs sampled with missReq appears on victimWay in that same following cycle.
- R3: The age code bits 5..0 each compare one pair of ways, in this order: (0,1), (0,2), (0,3), (1,2), (1,3), (2,3). A bit of 1 means the lower-numbered way of its pair is older. With neither lock bit set, the victim is the way that is older than all other ways.
- R4: When lockReg bit 0 (way-2 lock) is set and bit 8 is clear, way 2 is never chosen unless it is steered there. The victim is the oldest of ways 0, 1 and 3. For example, code 000100 selects way 3 and code 001011 selects way 1.
- R5: When lockReg bit 8 (way-3 lock) is set and bit 0 is clear, way 3 is never chosen unless it is steered there. The victim is the oldest of ways 0, 1 and 2. For example, code 000011 selects way 2 and code 000100 selects way 1.
- R6: When both lock bits are set and no steering applies, the victim is way 0 if code bit 5 is 1, and way 1 otherwise.
- R7: When prefetchFill, dspMode, lockReg bit 0 and lockReg bit 1 (way-2 load) are all 1, the victim is way 2.
- R8: When prefetchFill, dspMode, lockReg bit 8 and lockReg bit 9 (way-3 load) are all 1, the victim is way 3. Setting bits 1 and 9 together is undefined.
- R9: A load bit has no steering effect when dspMode, prefetchFill or its own lock bit is 0. In that case the lock still excludes its way, and the choice follows R3 to R6.
- R10: When no candidate way is older than every other candidate, as happens with a cyclic code, the victim is way 0.
- R11: ageNext equals ageCode with touchWay made the youngest way. Every pair bit that names touchWay as older becomes "other way older", and every bit not involving touchWay is unchanged.
- R12: victimWay keeps its last value in cycles that follow a cycle without missReq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| missReq | input | 1 | Victim request strobe |
| ageCode | input | 6 | Pairwise-age code of the set |
| lockReg | input | 10 | Lock/load control bits: 0 way-2 lock, 1 way-2 load, 8 way-3 lock, 9 way-3 load |
| dspMode | input | 1 | DSP mode flag |
| prefetchFill | input | 1 | The request is a prefetch fill |
| touchWay | input | 2 | Way touched by a hit or fill, input to the update helper |
| ageNext | output | 6 | Updated age code with touchWay youngest |
| victimValid | output | 1 | One-cycle pulse marking a new victim |
| victimWay | output | 2 | Registered victim way index |

## Verification
The bench steps through all 24 strict age orderings of the four ways. Each ordering is tried with no lock, each single lock and both locks, which separates the oldest-overall search from the searches that skip one or two ways. The same orderings are then repeated with the steering inputs in the full set and with one term missing, which separates a genuine override from a load bit that must stay inert. A cyclic code shows the fallback to way 0. Touching each way under every ordering checks that the update helper moves only the touched way's pairs. Back-to-back and spaced requests tell the valid pulse apart from the held way output.

// File: rtl/lock_lru_pkg.sv
package lock_lru_pkg;
  localparam int WAYS = 4;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PAIRS = WAYS * (WAYS - 1) / 2;
  localparam int IDX_W = $clog2(PAIRS);
  localparam int CTRL_W = 10;
  localparam int LOCK_LO_BIT = 0;
  localparam int LOAD_LO_BIT = 1;
  localparam int LOCK_HI_BIT = 8;
  localparam int LOAD_HI_BIT = 9;
  localparam int LO_WAY = 2;
  localparam int HI_WAY = 3;

  typedef struct packed {
    logic [WAYS-1:0] candMask;
    logic            steerLo;
    logic            steerHi;
    logic            capture;
  } pickCtl_t;

  // Bit position of pair (a,b), a<b; the first pair in enumeration order sits at the MSB.
  function automatic logic [IDX_W-1:0] pairBit(int a, int b);
    return IDX_W'(PAIRS - 1 - (a * WAYS - a * (a + 1) / 2 + (b - a - 1)));
  endfunction

  function automatic logic wayOlder(logic [PAIRS-1:0] code, int a, int b);
    if (a < b) return code[pairBit(a, b)];
    return ~code[pairBit(b, a)];
  endfunction
endpackage

// File: rtl/lock_lru_ctrl.sv
module lock_lru_ctrl
  import lock_lru_pkg::*;
(
  input  logic              missReq,
  input  logic [CTRL_W-1:0] lockReg,
  input  logic              dspMode,
  input  logic              prefetchFill,
  output pickCtl_t          ctl
);
  logic lockLo, loadLo, lockHi, loadHi;
  logic unusedCtrl;

  assign lockLo = lockReg[LOCK_LO_BIT];
  assign loadLo = lockReg[LOAD_LO_BIT];
  assign lockHi = lockReg[LOCK_HI_BIT];
  assign loadHi = lockReg[LOAD_HI_BIT];
  assign unusedCtrl = ^lockReg[LOCK_HI_BIT-1:LOAD_LO_BIT+1];

  always_comb begin
    ctl.candMask = '1;
    if (lockLo) ctl.candMask[LO_WAY] = 1'b0;
    if (lockHi) ctl.candMask[HI_WAY] = 1'b0;
    ctl.steerLo = prefetchFill & dspMode & lockLo & loadLo;
    ctl.steerHi = prefetchFill & dspMode & lockHi & loadHi;
    ctl.capture = missReq;
  end
endmodule

// File: rtl/lock_lru_dpath.sv
module lock_lru_dpath
  import lock_lru_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [PAIRS-1:0] ageCode,
  input  logic [WAY_W-1:0] touchWay,
  input  pickCtl_t         ctl,
  output logic [PAIRS-1:0] ageNext,
  output logic             victimValid,
  output logic [WAY_W-1:0] victimWay
);
  logic [WAYS-1:0]  isOldest;
  logic [WAY_W-1:0] lruPick;
  logic [WAY_W-1:0] pickNow;

  // One oldest-candidate test per way.
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic oldHere;
    always_comb begin
      oldHere = ctl.candMask[w];
      for (int v = 0; v < WAYS; v++) begin
        if (v != w && ctl.candMask[v] && !wayOlder(ageCode, w, v)) oldHere = 1'b0;
      end
    end
    assign isOldest[w] = oldHere;
  end

  // Lowest index wins; no winner falls back to way 0.
  always_comb begin
    lruPick = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (isOldest[w]) lruPick = WAY_W'(w);
    end
  end

  always_comb begin
    if (ctl.steerLo)      pickNow = WAY_W'(LO_WAY);
    else if (ctl.steerHi) pickNow = WAY_W'(HI_WAY);
    else                  pickNow = lruPick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      victimValid <= 1'b0;
      victimWay   <= '0;
    end else begin
      victimValid <= ctl.capture;
      if (ctl.capture) victimWay <= pickNow;
    end
  end

  // Update helper: the touched way becomes youngest in every pair it belongs to.
  always_comb begin
    ageNext = ageCode;
    for (int a = 0; a < WAYS; a++) begin
      for (int b = a + 1; b < WAYS; b++) begin
        if (touchWay == WAY_W'(a))      ageNext[pairBit(a, b)] = 1'b0;
        else if (touchWay == WAY_W'(b)) ageNext[pairBit(a, b)] = 1'b1;
      end
    end
  end

  assert_valid_after_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> victimValid);
  assert_valid_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> !victimValid);
  assert_skip_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.steerLo && !ctl.steerHi && !ctl.candMask[LO_WAY])
    |=> victimWay != WAY_W'(LO_WAY));
  assert_skip_hi_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.steerLo && !ctl.steerHi && !ctl.candMask[HI_WAY])
    |=> victimWay != WAY_W'(HI_WAY));
  assert_both_locked_R6: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && !ctl.steerLo && !ctl.steerHi && ctl.candMask == 4'b0011)
    |=> victimWay == ($past(ageCode[PAIRS-1]) ? 2'd0 : 2'd1));
  assert_steer_lo_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.steerLo) |=> victimWay == WAY_W'(LO_WAY));
  assert_steer_hi_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && ctl.steerHi && !ctl.steerLo) |=> victimWay == WAY_W'(HI_WAY));
  assert_hold_way_R12: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(victimWay));

  for (genvar v = 0; v < WAYS; v++) begin : g_updChk
    assert_touch_youngest_R11: assert property (@(posedge clk) disable iff (!rstN)
      (touchWay != WAY_W'(v)) |-> wayOlder(ageNext, v, int'(touchWay)));
  end
endmodule

// File: rtl/lock_lru_victim.sv
module lock_lru_victim
  import lock_lru_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              missReq,
  input  logic [PAIRS-1:0]  ageCode,
  input  logic [CTRL_W-1:0] lockReg,
  input  logic              dspMode,
  input  logic              prefetchFill,
  input  logic [WAY_W-1:0]  touchWay,
  output logic [PAIRS-1:0]  ageNext,
  output logic              victimValid,
  output logic [WAY_W-1:0]  victimWay
);
  pickCtl_t ctlBus;

  lock_lru_ctrl u_ctrl (
    .missReq      (missReq),
    .lockReg      (lockReg),
    .dspMode      (dspMode),
    .prefetchFill (prefetchFill),
    .ctl          (ctlBus)
  );

  lock_lru_dpath u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ageCode     (ageCode),
    .touchWay    (touchWay),
    .ctl         (ctlBus),
    .ageNext     (ageNext),
    .victimValid (victimValid),
    .victimWay   (victimWay)
  );
endmodule

// File: tb/lock_lru_victim_test.sv
`timescale 1ns/1ps
module lock_lru_victim_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       missReq = 1'b0;
  logic [5:0] ageCode = '0;
  logic [9:0] lockReg = '0;
  logic       dspMode = 1'b0;
  logic       prefetchFill = 1'b0;
  logic [1:0] touchWay = '0;
  logic [5:0] ageNext;
  logic       victimValid;
  logic [1:0] victimWay;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string curTag = "R3";

  always #2.5 clk = ~clk;

  lock_lru_victim uut (
    .clk(clk), .rstN(rstN), .missReq(missReq), .ageCode(ageCode),
    .lockReg(lockReg), .dspMode(dspMode), .prefetchFill(prefetchFill),
    .touchWay(touchWay), .ageNext(ageNext), .victimValid(victimValid),
    .victimWay(victimWay)
  );

  // Age relation read from the code: bits 5..0 are pairs 01,02,03,12,13,23.
  function automatic bit olderB(logic [5:0] c, int a, int b);
    int lo, hi, i;
    bit r;
    lo = (a < b) ? a : b;
    hi = (a < b) ? b : a;
    case (lo * 4 + hi)
      1: i = 5;  2: i = 4;  3: i = 3;
      6: i = 2;  7: i = 1;  default: i = 0;
    endcase
    r = c[i];
    return (a < b) ? r : !r;
  endfunction

  function automatic int refPick(logic [5:0] c, logic [9:0] cr, logic dsp, logic pf);
    bit cand[4];
    int nCand, wins;
    if (pf && dsp && cr[0] && cr[1]) return 2;
    if (pf && dsp && cr[8] && cr[9]) return 3;
    cand = '{1'b1, 1'b1, !cr[0], !cr[8]};
    nCand = 0;
    foreach (cand[k]) if (cand[k]) nCand++;
    for (int w = 0; w < 4; w++) begin
      if (!cand[w]) continue;
      wins = 0;
      for (int v = 0; v < 4; v++) if (v != w && cand[v] && olderB(c, w, v)) wins++;
      if (wins == nCand - 1) return w;
    end
    return 0;
  endfunction

  // rank: larger value means older.
  function automatic logic [5:0] codeOf(int rk[4]);
    return {rk[0] > rk[1], rk[0] > rk[2], rk[0] > rk[3],
            rk[1] > rk[2], rk[1] > rk[3], rk[2] > rk[3]};
  endfunction

  // Cycle reference model.
  logic  expValid = 1'b0;
  int    expWay = 0;
  string expTag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 1'b0;
      expWay   <= 0;
    end else begin
      expValid <= missReq;
      if (missReq) begin
        expWay <= refPick(ageCode, lockReg, dspMode, prefetchFill);
        expTag <= curTag;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (!rstN) begin
        if (victimValid !== 1'b0 || victimWay !== 2'd0) begin
          failures++;
          $display("FAIL R1 reset: valid=%b way=%0d expected valid=0 way=0", victimValid, victimWay);
        end
      end else if (victimValid !== expValid || int'(victimWay) != expWay) begin
        failures++;
        $display("FAIL %s %s: valid=%b way=%0d expected valid=%b way=%0d",
                 expValid ? expTag : "R2 R12", expValid ? "victim" : "idle",
                 victimValid, victimWay, expValid, expWay);
      end
    end
  end

  task automatic doReq(logic [5:0] c, logic [9:0] cr, logic dsp, logic pf, string tag);
    @(negedge clk);
    ageCode = c; lockReg = cr; dspMode = dsp; prefetchFill = pf;
    curTag = tag; missReq = 1'b1;
    @(negedge clk);
    missReq = 1'b0;
  endtask

  task automatic directReq(logic [5:0] c, logic [9:0] cr, logic dsp, logic pf, int exp, string tag);
    doReq(c, cr, dsp, pf, tag);
    #0.5;
    checks++;
    if (int'(victimWay) != exp) begin
      failures++;
      $display("FAIL %s direct: way=%0d expected %0d", tag, victimWay, exp);
    end
  endtask

  initial begin
    int rk[4];
    int nr[4];
    logic [5:0] expNext;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Orderings under every lock combination and the steering variants.
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 4; c++)
          for (int d = 0; d < 4; d++) begin
            if (a == b || a == c || a == d || b == c || b == d || c == d) continue;
            rk = '{a, b, c, d};
            doReq(codeOf(rk), 10'h000, 1'b0, 1'b0, "R3");
            doReq(codeOf(rk), 10'h001, 1'b0, 1'b0, "R4");
            doReq(codeOf(rk), 10'h100, 1'b0, 1'b0, "R5");
            doReq(codeOf(rk), 10'h101, 1'b0, 1'b0, "R6");
            doReq(codeOf(rk), 10'h003, 1'b1, 1'b1, "R7");
            doReq(codeOf(rk), 10'h300, 1'b1, 1'b1, "R8");
            doReq(codeOf(rk), 10'h003, 1'b0, 1'b1, "R9");
            doReq(codeOf(rk), 10'h303 & 10'h103, 1'b1, 1'b0, "R9");
            doReq(codeOf(rk), 10'h002, 1'b1, 1'b1, "R9");
            // Update helper with every touched way.
            for (int w = 0; w < 4; w++) begin
              @(negedge clk);
              ageCode = codeOf(rk);
              touchWay = 2'(w);
              for (int v = 0; v < 4; v++)
                nr[v] = (v == w) ? 0 : ((rk[v] < rk[w]) ? rk[v] + 1 : rk[v]);
              expNext = codeOf(nr);
              #1;
              checks++;
              if (ageNext !== expNext) begin
                failures++;
                $display("FAIL R11 update: ageNext=%b expected %b", ageNext, expNext);
              end
            end
          end

    // Fixed values from the lock requirements.
    directReq(6'b000100, 10'h001, 1'b0, 1'b0, 3, "R4");
    directReq(6'b001011, 10'h001, 1'b0, 1'b0, 1, "R4");
    directReq(6'b000011, 10'h100, 1'b0, 1'b0, 2, "R5");
    directReq(6'b000100, 10'h100, 1'b0, 1'b0, 1, "R5");
    directReq(6'b100000, 10'h101, 1'b0, 1'b0, 0, "R6");
    directReq(6'b011111, 10'h101, 1'b0, 1'b0, 1, "R6");
    directReq(6'b111111, 10'h003, 1'b1, 1'b1, 2, "R7");
    directReq(6'b000000, 10'h300, 1'b1, 1'b1, 3, "R8");
    directReq(6'b100111, 10'h000, 1'b0, 1'b0, 0, "R10");
    directReq(6'b100111, 10'h100, 1'b0, 1'b0, 0, "R10");

    // Back-to-back requests, then idle cycles that must hold the way.
    @(negedge clk);
    curTag = "R2";
    missReq = 1'b1;
    for (int k = 0; k < 6; k++) begin
      ageCode = (k % 2 == 0) ? 6'b000000 : 6'b111111;
      lockReg = 10'h000;
      dspMode = 1'b0; prefetchFill = 1'b0;
      @(negedge clk);
    end
    missReq = 1'b0;
    ageCode = 6'b000000;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule